// File: doc/BRIEF.md
# Two-Wire Block-Transfer Slave with Register File

This block is a slave on a two-wire serial bus (SMBus and I2C). It sits behind a two-flop synchronizer on the clock and data lines and drives the data line only through an open-drain pull-low enable. It finds START, repeated START and STOP conditions, compares a 7-bit device address, and treats the first byte of every write phase as a command. The low bits of the command load a register pointer and the top bit marks a block transfer. The slave serves a small register file of bytes, and the pointer moves on after every byte it moves.

In a block write, the master sends a byte-count field right after the command. The slave acknowledges that field and then discards it. The number of bytes actually stored is set only by how many complete data bytes arrive before STOP. Reads can start in two ways: straight after a read address, or inside a combined transfer after a repeated START with the read bit set. Either way the read begins at the current pointer. The slave keeps sending bytes until the master answers one with NACK. A STOP or repeated START that arrives in the middle of a byte drops that byte.

Top module: `smb_slave`

## Requirements
- R1: After reset, `sda_oe_o` is low, every register holds 0x00 and the pointer is 0.
- R2: An address byte is 7 address bits, MSB first, then a direction bit (0 = write, 1 = read). The slave pulls SDA low in the acknowledge slot only when the address equals `DEV_ADDR`. On a mismatch it does not drive SDA until the next START or STOP.
- R3: In a write phase, the first byte after the address is a command. Bits [PTR_W-1:0] load the pointer, bit 7 = 1 marks a block transfer, and the slave acknowledges the byte.
- R4: In a write phase, each data byte is acknowledged and stored at the pointer, and the pointer then advances by one.
- R5: When the command has bit 7 set, the next byte in the same write phase is acknowledged and discarded, and no register changes. Every later byte up to STOP is stored as data.
- R6: In a read, bytes go out MSB first starting at the pointer, and the pointer advances once per byte sent. Sending continues while the master acknowledges. After a NACK, SDA is released until the next START or STOP.
- R7: A read can follow a read address directly, or follow a repeated START after a command. In both cases it starts at the current pointer.
- R8: The pointer wraps from 2**PTR_W-1 to 0, for writes and for reads.
- R9: A STOP received before all eight bits of a data byte leaves the registers and the pointer unchanged and returns the slave to idle.
- R10: A repeated START received in the middle of a byte drops that byte and begins a new address phase, which is then served normally.
- R11: SDA is pulled low only in acknowledge slots and in bits the slave transmits, and the pull-low enable never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; bus lines are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench aims at the count field of a block write. A design that stored it would overwrite the register at the pointer and shift every following byte by one address. Writes and reads run across the top register so the pointer has to wrap; a design that saturated the pointer or ran past the end would read back the wrong byte there. Both kinds of interrupted byte are tested, a STOP after four bits and a repeated START after five. A design that committed partial data, or lost track of the new address phase, would show a changed register or a missing acknowledge. After the master's NACK and after an address mismatch, the bench keeps clocking the bus and watches every clock for SDA being pulled low. A slave that kept sending or acknowledged a foreign address would be caught there.

// File: rtl/smb_slave_pkg.sv
package smb_slave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } st_e;

endpackage

// File: rtl/smb_line_cond.sv
// Two-flop synchronizer for the bus lines plus edge and bus-condition detection.
module smb_line_cond (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [1:0] meta;
        logic [1:0] sync;
        logic [1:0] prev;
    } sy_t;

    sy_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.meta = {scl_i, sda_i};
        sy_d.sync = sy_q.meta;
        sy_d.prev = sy_q.sync;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sy_q <= '1;
        else         sy_q <= sy_d;
    end

    assign scl_o      = sy_q.sync[1];
    assign sda_o      = sy_q.sync[0];
    assign scl_rise_o = sy_q.sync[1] & ~sy_q.prev[1];
    assign scl_fall_o = ~sy_q.sync[1] & sy_q.prev[1];
    // data edge while the clock stays high
    assign start_o    = sy_q.sync[1] & sy_q.prev[1] & sy_q.prev[0] & ~sy_q.sync[0];
    assign stop_o     = sy_q.sync[1] & sy_q.prev[1] & ~sy_q.prev[0] & sy_q.sync[0];
endmodule

// File: rtl/smb_regbank.sv
// Byte register file: one synchronous write port, one combinational read port.
module smb_regbank #(
    parameter int PTR_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [PTR_W-1:0] waddr_i,
    input  logic [7:0]       wdata_i,
    input  logic [PTR_W-1:0] raddr_i,
    output logic [7:0]       rdata_o
);
    localparam int DEPTH = 1 << PTR_W;

    logic [7:0] regs_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        logic [7:0] cell_d;
        always_comb begin
            cell_d = regs_q[g];
            if (we_i && (waddr_i == PTR_W'(g))) cell_d = wdata_i;
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) regs_q[g] <= '0;
            else         regs_q[g] <= cell_d;
        end
    end

    assign rdata_o = regs_q[raddr_i];
endmodule

// File: rtl/smb_slave.sv
// Two-wire slave: address match, command/pointer, block count discard, read/write bursts.
module smb_slave #(
    parameter logic [6:0] DEV_ADDR = 7'h3A,
    parameter int         PTR_W    = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);
    import smb_slave_pkg::*;

    localparam int               CNT_W   = 4;
    localparam logic [CNT_W-1:0] BITS    = CNT_W'(8);
    localparam logic [CNT_W-1:0] LASTBIT = CNT_W'(7);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
    localparam logic [1:0]       IDX_MAX = 2'd2;

    typedef struct packed {
        st_e              st;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       sh;
        logic [PTR_W-1:0] ptr;
        logic             rw;
        logic             blk;
        logic [1:0]       idx;
        logic             oe;
        logic             nack;
    } ctl_t;

    ctl_t       c_d, c_q;
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       reg_we;
    logic [7:0] rdata;

    smb_line_cond u_cond (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    smb_regbank #(.PTR_W(PTR_W)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (reg_we),
        .waddr_i (c_q.ptr),
        .wdata_i (c_q.sh),
        .raddr_i (c_q.ptr),
        .rdata_o (rdata)
    );

    always_comb begin
        c_d    = c_q;
        reg_we = 1'b0;
        if (stop_det) begin
            c_d.st = ST_IDLE;
            c_d.oe = 1'b0;
        end else if (start_det) begin
            c_d.st  = ST_ADDR;
            c_d.cnt = '0;
            c_d.idx = '0;
            c_d.oe  = 1'b0;
        end else begin
            unique case (c_q.st)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        c_d.sh  = {c_q.sh[6:0], sda_s};
                        c_d.cnt = c_q.cnt + 1'b1;
                    end else if (scl_fall && c_q.cnt == BITS) begin
                        if (c_q.sh[7:1] == DEV_ADDR) begin
                            c_d.st = ST_ADDR_ACK;
                            c_d.oe = 1'b1;
                            c_d.rw = c_q.sh[0];
                        end else begin
                            c_d.st = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        c_d.cnt = '0;
                        if (c_q.rw) begin
                            c_d.st  = ST_TX;
                            c_d.sh  = rdata;
                            c_d.ptr = c_q.ptr + PTR_ONE;
                            c_d.oe  = ~rdata[7];
                        end else begin
                            c_d.st = ST_RX;
                            c_d.oe = 1'b0;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        c_d.sh  = {c_q.sh[6:0], sda_s};
                        c_d.cnt = c_q.cnt + 1'b1;
                    end else if (scl_fall && c_q.cnt == BITS) begin
                        c_d.st = ST_RX_ACK;
                        c_d.oe = 1'b1;
                        if (c_q.idx != IDX_MAX) c_d.idx = c_q.idx + 1'b1;
                        if (c_q.idx == 2'd0) begin
                            c_d.ptr = c_q.sh[PTR_W-1:0];
                            c_d.blk = c_q.sh[7];
                        end else if (!(c_q.idx == 2'd1 && c_q.blk)) begin
                            reg_we  = 1'b1;
                            c_d.ptr = c_q.ptr + PTR_ONE;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        c_d.st  = ST_RX;
                        c_d.cnt = '0;
                        c_d.oe  = 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (c_q.cnt == LASTBIT) begin
                            c_d.st = ST_TX_ACK;
                            c_d.oe = 1'b0;
                        end else begin
                            c_d.sh  = {c_q.sh[6:0], 1'b0};
                            c_d.oe  = ~c_q.sh[6];
                            c_d.cnt = c_q.cnt + 1'b1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        c_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (c_q.nack) begin
                            c_d.st = ST_IDLE;
                        end else begin
                            c_d.st  = ST_TX;
                            c_d.sh  = rdata;
                            c_d.ptr = c_q.ptr + PTR_ONE;
                            c_d.oe  = ~rdata[7];
                            c_d.cnt = '0;
                        end
                    end
                end
                default: c_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe_o = c_q.oe;
endmodule

// File: rtl/smb_slave_chk.sv
module smb_slave_chk #(
    parameter int PTR_W = 3
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic                      scl_s,
    input logic                      scl_fall,
    input logic                      stop_det,
    input logic                      sda_oe_o,
    input smb_slave_pkg::st_e        st,
    input logic                      reg_we,
    input logic [PTR_W-1:0]          ptr
);
    import smb_slave_pkg::*;

    // R11
    oe_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sda_oe_o |-> (st == ST_ADDR_ACK || st == ST_RX_ACK || st == ST_TX));

    // R11
    oe_scl_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

    // R9
    stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_det |=> (!sda_oe_o && st == ST_IDLE));

    // R4
    ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_we |=> (ptr == $past(ptr) + PTR_W'(1)));

    // R3
    ptr_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ptr) |-> $past(scl_fall));
endmodule

bind smb_slave smb_slave_chk #(.PTR_W(PTR_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_s    (scl_s),
    .scl_fall (scl_fall),
    .stop_det (stop_det),
    .sda_oe_o (sda_oe_o),
    .st       (c_q.st),
    .reg_we   (reg_we),
    .ptr      (c_q.ptr)
);

// File: tb/smb_slave_tb_top.sv
module smb_slave_tb_top;
    localparam logic [6:0] DEV   = 7'h3A;
    localparam int         PTR_W = 3;
    localparam int         DEPTH = 1 << PTR_W;
    localparam int         Q     = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    wire  sda_line = sda_m & ~sda_oe;

    int   tests = 0;
    int   fails = 0;
    int   viol = 0;
    bit   may_drive = 1'b0;
    bit   done = 1'b0;

    logic [7:0] mem [DEPTH];
    int         mptr = 0;

    always #5 clk = ~clk;

    smb_slave #(.DEV_ADDR(DEV), .PTR_W(PTR_W)) dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe)
    );

    // reference: slave may only pull low inside windows the master opened
    always @(negedge clk) if (rst_n && sda_oe && !may_drive) viol++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic start_c();
        sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl = 1'b0; w(Q);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; w(Q); scl = 1'b1; w(Q); sda_m = 1'b1; w(Q);
    endtask

    task automatic bit_out(input logic b, input bit allow_after);
        sda_m = b; w(Q); scl = 1'b1; w(2*Q); may_drive = allow_after; scl = 1'b0; w(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); b = sda_line; w(Q); scl = 1'b0; w(Q);
    endtask

    task automatic wr_byte(input logic [7:0] v, input bit keep, output logic ack);
        for (int i = 7; i >= 1; i--) bit_out(v[i], 1'b0);
        bit_out(v[0], 1'b1);
        bit_in(ack);
        may_drive = keep;
    endtask

    task automatic rd_byte(input bit last, output logic [7:0] v);
        logic b;
        may_drive = 1'b1;
        for (int i = 0; i < 8; i++) begin
            bit_in(b);
            v = {v[6:0], b};
        end
        may_drive = 1'b0;
        bit_out(last, !last);
    endtask

    task automatic addr(input bit rd, input string req);
        logic a;
        wr_byte({DEV, rd}, rd, a);
        chk(a == 1'b0, req, a, 0);
    endtask

    task automatic cmd(input logic [7:0] c, input string req);
        logic a;
        wr_byte(c, 1'b0, a);
        chk(a == 1'b0, req, a, 0);
        mptr = c[PTR_W-1:0];
    endtask

    task automatic wdat(input logic [7:0] d, input string req);
        logic a;
        wr_byte(d, 1'b0, a);
        chk(a == 1'b0, req, a, 0);
        mem[mptr] = d;
        mptr = (mptr + 1) % DEPTH;
    endtask

    task automatic rexp(input bit last, input string req);
        logic [7:0] v;
        rd_byte(last, v);
        chk(v == mem[mptr], req, v, mem[mptr]);
        mptr = (mptr + 1) % DEPTH;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_up();
    end

    initial begin
        logic a;
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
        w(5);
        chk(sda_oe == 1'b0, "R1 oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        w(5);
        chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);

        // R2 foreign write address: NACK, then silent for a following byte
        start_c();
        wr_byte({7'h55, 1'b0}, 1'b0, a);
        chk(a == 1'b1, "R2 mismatch nack", a, 1);
        wr_byte(8'h00, 1'b0, a);
        chk(a == 1'b1, "R2 silent after mismatch", a, 1);
        stop_c();

        // R3 R4 plain write of three bytes from pointer 2
        start_c(); addr(0, "R2 match ack");
        cmd(8'h02, "R3 cmd ack");
        wdat(8'hA1, "R4 data ack"); wdat(8'hA2, "R4 data ack"); wdat(8'hA3, "R4 data ack");
        stop_c();

        // R7 combined read from pointer 2
        start_c(); addr(0, "R7 addr");
        cmd(8'h02, "R3 cmd");
        start_c(); addr(1, "R7 read addr");
        rexp(0, "R4 R7 rd0"); rexp(0, "R4 rd1"); rexp(1, "R4 rd2");
        stop_c();

        // R7 read directly after address from current pointer (5)
        start_c(); addr(1, "R7 direct addr");
        rexp(1, "R7 direct rd");
        stop_c();

        // R5 R8 block write at 6: count 0x02 discarded, third data wraps to 0
        start_c(); addr(0, "R5 addr");
        cmd(8'h86, "R5 block cmd");
        wr_byte(8'h02, 1'b0, a);
        chk(a == 1'b0, "R5 count ack", a, 0);
        wdat(8'h11, "R5 data"); wdat(8'h22, "R5 data"); wdat(8'h33, "R8 wrapped data");
        stop_c();

        // R8 R6 read from 5 across the wrap, then master clocks one more byte after NACK
        start_c(); addr(0, "R8 addr");
        cmd(8'h05, "R8 cmd");
        start_c(); addr(1, "R8 read addr");
        rexp(0, "R5 reg5 untouched"); rexp(0, "R5 reg6"); rexp(0, "R8 reg7"); rexp(1, "R8 reg0 wrap");
        rd_byte(1'b1, v);
        chk(v == 8'hFF, "R6 released after nack", v, 8'hFF);
        stop_c();

        // R5 block read after command, no count involved
        start_c(); addr(0, "R5 blk rd addr");
        cmd(8'h82, "R5 blk rd cmd");
        start_c(); addr(1, "R5 blk rd raddr");
        rexp(1, "R5 block read");
        stop_c();

        // R9 STOP after four data bits
        start_c(); addr(0, "R9 addr");
        cmd(8'h01, "R9 cmd");
        for (int i = 0; i < 4; i++) bit_out(1'b1, 1'b0);
        stop_c();
        start_c(); addr(1, "R9 read addr");
        rexp(1, "R9 no partial write");
        stop_c();

        // R10 repeated START after five bits of a data byte
        start_c(); addr(0, "R10 addr");
        cmd(8'h03, "R10 cmd");
        for (int i = 0; i < 5; i++) bit_out(1'b0, 1'b0);
        start_c(); addr(1, "R10 new addr phase");
        rexp(1, "R10 reg3 kept");
        stop_c();

        // R2 foreign read address
        start_c();
        wr_byte({7'h3B, 1'b1}, 1'b0, a);
        chk(a == 1'b1, "R2 read mismatch nack", a, 1);
        stop_c();

        w(20);
        chk(viol == 0, "R11 SDA driven outside slave slots", viol, 0);
        finish_up();
    end
endmodule